// File: doc/BRIEF.md
# Four-Channel PWM Generator with Boundary-Committed Updates

This block produces four independent pulse-width-modulated outputs, programmed through a small register bus. A register access takes a single cycle: write strobe, address and data in, combinational read data out, plus a read strobe that marks read-side effects. Each channel holds a clock prescaler, an alignment choice, an output polarity, a compare value, a period and a running counter. Global registers start and stop channels with write-one masks, report which channels are running, and handle end-of-period interrupts.

A running channel does not accept direct changes to its compare or period value, so that a half-written pair never produces a glitch. Software instead writes a staging register. Its content lands at the next end of period, in the compare value or in the period value as a mode bit selects. Channels started by one mask write begin counting on the same clock edge, so their periods stay in phase. Each end of period sets a pending bit. One interrupt line is asserted while any pending bit is enabled.

Top module: `pwm_bank`

## Requirements
- R1: Channel n's registers sit at byte 0x200 + 0x20·n: mode at +0x00, compare at +0x04, period at +0x08, counter at +0x0C (read-only), staging at +0x10. Mode keeps the prescaler in bits [3:0], center alignment at bit 8, polarity at bit 9 and staging target at bit 10. Other bits read back 0, and a prescaler above 10 is stored as 10.
- R2: A write to global offset 0x04 starts every stopped channel whose bit is 1, all on the same edge, with the counter starting from 0. Zero bits have no effect. Global offset 0x0C reads bit n as 1 while channel n runs.
- R3: A write to global offset 0x08 stops every channel whose bit is 1. A stopped channel holds its counter at 0 and drives the inverse of its polarity bit. Zero bits have no effect.
- R4: A running channel's counter steps once every 2^prescaler input clocks.
- R5: With bit 8 clear, the counter runs 0, 1, … period−1 and then returns to 0. The return to 0 is the end of period.
- R6: With bit 8 set, the counter rises from 0 to the period value and falls back. The end of period is the step that reaches 0 again.
- R7: A running channel drives its output equal to its polarity bit while counter ≥ compare, and drives the inverse otherwise.
- R8: Compare and period writes take effect at once on a stopped channel and are ignored on a running one.
- R9: A staging write to a running channel is held and committed at its next end of period, into compare when bit 10 is 0 and into period when it is 1. On a stopped channel it goes to that target at once.
- R10: Every end of period sets the channel's bit in the pending register (global 0x1C). A read of 0x1C returns the pending bits and clears them.
- R11: Writing ones to global 0x10 sets enable bits and writing ones to 0x14 clears them; 0x18 reads the enables. The interrupt output is high while any pending bit is also enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (drives read-to-clear) |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 4 | Channel outputs |
| irq | output | 1 | Combined end-of-period interrupt |

## Verification
Some properties are checked by assertions on every cycle. A stopped channel keeps its counter at zero. A running counter never passes its period. An end of period returns the counter to zero. A staging commit lands the held value in the selected target. A running channel's compare value is stable except at a commit. Start and stop masks reach the run bits on the next edge. Prescaler ticks are never adjacent when the divider is above one. Every end of period is captured as pending. The bench's cycle model covers what no single property can show: the full waveform of each output under both alignments and several prescalers, the exact period in which a staged value becomes visible, in-phase starts, the clearing effect of reads, and the masked readback of the mode register.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int CW      = 16;
  localparam int PRE_W   = 4;
  localparam int PRE_MAX = 10;
  localparam int DIV_W   = PRE_MAX;

  localparam logic [PRE_W-1:0] PRE_CAP = PRE_W'(PRE_MAX);
  localparam logic [CW-1:0]    C_ONE   = CW'(1);

  // global register offsets (within 0x000..0x01F)
  localparam logic [4:0] G_MODE = 5'h00;
  localparam logic [4:0] G_ENA  = 5'h04;
  localparam logic [4:0] G_DIS  = 5'h08;
  localparam logic [4:0] G_STAT = 5'h0C;
  localparam logic [4:0] G_IEN  = 5'h10;
  localparam logic [4:0] G_IDIS = 5'h14;
  localparam logic [4:0] G_IMSK = 5'h18;
  localparam logic [4:0] G_IPND = 5'h1C;

  // per-channel offsets
  localparam logic [4:0] C_MODE = 5'h00;
  localparam logic [4:0] C_CMP  = 5'h04;
  localparam logic [4:0] C_PRD  = 5'h08;
  localparam logic [4:0] C_CNT  = 5'h0C;
  localparam logic [4:0] C_STG  = 5'h10;

  localparam int MB_CENTER = 8;
  localparam int MB_POL    = 9;
  localparam int MB_TARGET = 10;

  typedef struct packed {
    logic             to_prd;
    logic             pol;
    logic             center;
    logic [PRE_W-1:0] pre;
  } cmode_t;

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic          down;
    logic          wrap;
  } step_t;

  function automatic cmode_t decode_mode(input logic [31:0] w);
    cmode_t m;
    m.pre    = (w[PRE_W-1:0] > PRE_CAP) ? PRE_CAP : w[PRE_W-1:0];
    m.center = w[MB_CENTER];
    m.pol    = w[MB_POL];
    m.to_prd = w[MB_TARGET];
    return m;
  endfunction

  function automatic logic [31:0] encode_mode(input cmode_t m);
    logic [31:0] r;
    r = '0;
    r[PRE_W-1:0]  = m.pre;
    r[MB_CENTER]  = m.center;
    r[MB_POL]     = m.pol;
    r[MB_TARGET]  = m.to_prd;
    return r;
  endfunction

  function automatic logic [DIV_W-1:0] div_limit(input logic [PRE_W-1:0] pre);
    logic [31:0] full;
    full = (32'd1 << pre) - 32'd1;
    return full[DIV_W-1:0];
  endfunction

  // one counter step; wrap marks the end of period
  function automatic step_t count_step(input logic [CW-1:0] cnt, input logic down,
                                       input logic [CW-1:0] prd, input logic center);
    step_t s;
    s.cnt  = cnt;
    s.down = down;
    s.wrap = 1'b0;
    if (!center) begin
      s.down = 1'b0;
      if (({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, prd}) begin
        s.cnt  = '0;
        s.wrap = 1'b1;
      end else begin
        s.cnt = cnt + C_ONE;
      end
    end else if (!down) begin
      if (cnt >= prd) begin
        if (cnt <= C_ONE) begin
          s.cnt  = '0;
          s.down = 1'b0;
          s.wrap = 1'b1;
        end else begin
          s.cnt  = cnt - C_ONE;
          s.down = 1'b1;
        end
      end else begin
        s.cnt = cnt + C_ONE;
      end
    end else begin
      if (cnt <= C_ONE) begin
        s.cnt  = '0;
        s.down = 1'b0;
        s.wrap = 1'b1;
      end else begin
        s.cnt = cnt - C_ONE;
      end
    end
    return s;
  endfunction

  function automatic logic drive_level(input logic run, input logic [CW-1:0] cnt,
                                       input logic [CW-1:0] cmp, input logic pol);
    if (!run) return !pol;
    return (cnt >= cmp) ? pol : !pol;
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim  = div_limit(pre);
  assign tick = run && (div_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + DIV_W'(1);
  end

  // R4: with a divider above one, ticks are never on adjacent cycles
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || pre == '0));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          wr_mode,
  input  logic          wr_cmp,
  input  logic          wr_prd,
  input  logic          wr_stg,
  input  logic [31:0]   wdata,
  output logic          run,
  output cmode_t        mode,
  output logic [CW-1:0] cmp,
  output logic [CW-1:0] prd,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] stg,
  output logic          eop,
  output logic          pwm
);

  logic          run_q, down_q, pend_q, tick;
  cmode_t        mode_q;
  logic [CW-1:0] cmp_q, prd_q, cnt_q, stg_q;
  step_t         st;
  logic          commit_cmp, commit_prd;
  logic          direct_cmp, direct_prd;

  pwm_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .pre   (mode_q.pre),
    .tick  (tick)
  );

  assign st         = count_step(cnt_q, down_q, prd_q, mode_q.center);
  assign eop        = tick & st.wrap;
  assign commit_cmp = eop & pend_q & ~mode_q.to_prd;
  assign commit_prd = eop & pend_q &  mode_q.to_prd;
  assign direct_cmp = ~run_q & (wr_cmp | (wr_stg & ~mode_q.to_prd));
  assign direct_prd = ~run_q & (wr_prd | (wr_stg &  mode_q.to_prd));

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (stop)   run_q <= 1'b0;
    else if (start)  run_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_q || stop) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= st.cnt;
      down_q <= st.down;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= decode_mode(wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cmp_q <= '0;
    else if (commit_cmp) cmp_q <= stg_q;
    else if (direct_cmp) cmp_q <= wdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          prd_q <= '0;
    else if (commit_prd) prd_q <= stg_q;
    else if (direct_prd) prd_q <= wdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      stg_q <= '0;
    else if (wr_stg) stg_q <= wdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop)        pend_q <= 1'b0;
    else if (wr_stg && run_q)  pend_q <= 1'b1;
    else if (eop)              pend_q <= 1'b0;
  end

  assign run  = run_q;
  assign mode = mode_q;
  assign cmp  = cmp_q;
  assign prd  = prd_q;
  assign cnt  = cnt_q;
  assign stg  = stg_q;
  assign pwm  = drive_level(run_q, cnt_q, cmp_q, mode_q.pol);

  // R3: a stopped channel holds its counter at zero
  a_r3_stopped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> cnt_q == '0);
  // R5 / R6: a running counter never passes its period
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q <= prd_q);
  // R5 / R6: the end of period returns the counter to zero
  a_r5_eop_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> cnt_q == '0);
  // R9: committed staging value lands in the selected target
  a_r9_commit_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    commit_cmp |=> cmp_q == $past(stg_q));
  a_r9_commit_prd: assert property (@(posedge clk) disable iff (!rst_n)
    commit_prd |=> prd_q == $past(stg_q));
  // R8: a running channel's compare changes only through a commit
  a_r8_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !commit_cmp) |=> $stable(cmp_q));

endmodule

// File: rtl/pwm_irq_ctl.sv
module pwm_irq_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] eop,
  input  logic [NCH-1:0] ien_set,
  input  logic [NCH-1:0] idis_clr,
  input  logic           rd_clr,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] mask,
  output logic           irq
);

  logic [NCH-1:0] pend_q, mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (rd_clr ? '0 : pend_q) | eop;
      mask_q <= (mask_q | ien_set) & ~idis_clr;
    end
  end

  assign pend = pend_q;
  assign mask = mask_q;
  assign irq  = |(pend_q & mask_q);

  // R10: every end of period is captured as pending
  a_r10_pend_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (eop != '0) |=> ((pend_q & $past(eop)) == $past(eop)));
  // R10: a read with no new event leaves nothing pending
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && eop == '0) |=> pend_q == '0);
  // R11: enable writes set mask bits unless cleared in the same write
  a_r11_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set != '0) |=> ((mask_q & $past(ien_set & ~idis_clr)) == $past(ien_set & ~idis_clr)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [11:0]    bus_addr,
  input  logic [31:0]    bus_wdata,
  input  logic           bus_we,
  input  logic           bus_re,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out,
  output logic           irq
);

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [4:0]      off;
  logic            glob_hit, chan_hit;
  logic [CH_W-1:0] csel;
  logic [NCH-1:0]  ena_mask, dis_mask, ien_mask, idis_mask;
  logic            rd_clr;

  logic [NCH-1:0]  run_v, eop_v, pend_v, mask_v;
  cmode_t          mode_a [NCH];
  logic [CW-1:0]   cmp_a  [NCH];
  logic [CW-1:0]   prd_a  [NCH];
  logic [CW-1:0]   cnt_a  [NCH];
  logic [CW-1:0]   stg_a  [NCH];

  assign off      = bus_addr[4:0];
  assign csel     = bus_addr[5 +: CH_W];
  assign glob_hit = (bus_addr[11:5] == 7'd0);
  assign chan_hit = (bus_addr[11:9] == 3'b001) && ((bus_addr[8:5] >> CH_W) == 4'd0)
                    && (32'(csel) < NCH);

  assign ena_mask  = (bus_we && glob_hit && off == G_ENA)  ? bus_wdata[NCH-1:0] : '0;
  assign dis_mask  = (bus_we && glob_hit && off == G_DIS)  ? bus_wdata[NCH-1:0] : '0;
  assign ien_mask  = (bus_we && glob_hit && off == G_IEN)  ? bus_wdata[NCH-1:0] : '0;
  assign idis_mask = (bus_we && glob_hit && off == G_IDIS) ? bus_wdata[NCH-1:0] : '0;
  assign rd_clr    = bus_re && glob_hit && off == G_IPND;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_i;
    assign sel_i = bus_we && chan_hit && (32'(csel) == i);

    pwm_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (ena_mask[i]),
      .stop    (dis_mask[i]),
      .wr_mode (sel_i && off == C_MODE),
      .wr_cmp  (sel_i && off == C_CMP),
      .wr_prd  (sel_i && off == C_PRD),
      .wr_stg  (sel_i && off == C_STG),
      .wdata   (bus_wdata),
      .run     (run_v[i]),
      .mode    (mode_a[i]),
      .cmp     (cmp_a[i]),
      .prd     (prd_a[i]),
      .cnt     (cnt_a[i]),
      .stg     (stg_a[i]),
      .eop     (eop_v[i]),
      .pwm     (pwm_out[i])
    );
  end

  pwm_irq_ctl #(.NCH(NCH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .eop      (eop_v),
    .ien_set  (ien_mask),
    .idis_clr (idis_mask),
    .rd_clr   (rd_clr),
    .pend     (pend_v),
    .mask     (mask_v),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (glob_hit) begin
      case (off)
        G_STAT:  bus_rdata[NCH-1:0] = run_v;
        G_IMSK:  bus_rdata[NCH-1:0] = mask_v;
        G_IPND:  bus_rdata[NCH-1:0] = pend_v;
        default: bus_rdata = '0;
      endcase
    end else if (chan_hit) begin
      case (off)
        C_MODE:  bus_rdata = encode_mode(mode_a[csel]);
        C_CMP:   bus_rdata[CW-1:0] = cmp_a[csel];
        C_PRD:   bus_rdata[CW-1:0] = prd_a[csel];
        C_CNT:   bus_rdata[CW-1:0] = cnt_a[csel];
        C_STG:   bus_rdata[CW-1:0] = stg_a[csel];
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2: every channel named in a start mask is running on the next edge
  a_r2_start_together: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_mask != '0) |=> ((run_v & $past(ena_mask)) == $past(ena_mask)));
  // R3: every channel named in a stop mask is stopped on the next edge
  a_r3_stop_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_mask != '0) |=> ((run_v & $past(dis_mask)) == '0));

endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

  localparam int CLK_NS = 10;
  localparam int NCH    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit live   = 0;
  bit done   = 0;

  // behavioural model state
  int m_run[NCH], m_div[NCH], m_cnt[NCH], m_down[NCH];
  int m_cmp[NCH], m_prd[NCH], m_stg[NCH], m_pend[NCH];
  int m_pre[NCH], m_ctr[NCH], m_pol[NCH], m_tgt[NCH];
  int m_ip, m_im;

  pwm_bank #(.NCH(NCH)) i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_run[i] = 0; m_div[i] = 0; m_cnt[i] = 0; m_down[i] = 0;
        m_cmp[i] = 0; m_prd[i] = 0; m_stg[i] = 0; m_pend[i] = 0;
        m_pre[i] = 0; m_ctr[i] = 0; m_pol[i] = 0; m_tgt[i] = 0;
      end
      m_ip = 0; m_im = 0;
    end else begin
      int a, w, ev;
      bit g, c;
      a  = int'(bus_addr);
      w  = int'(bus_wdata);
      g  = a < 'h20;
      c  = a >= 'h200 && a < 'h280;
      ev = 0;
      for (int i = 0; i < NCH; i++) begin
        bit tick, wrap, cw, go, halt;
        int nc, nd;
        cw   = bus_we && c && ((a - 'h200) / 'h20) == i;
        go   = bus_we && g && (a % 'h20) == 'h04 && w[i];
        halt = bus_we && g && (a % 'h20) == 'h08 && w[i];
        tick = m_run[i] != 0 && m_div[i] >= (1 << m_pre[i]) - 1;
        nc = m_cnt[i]; nd = m_down[i]; wrap = 0;
        if (m_ctr[i] == 0) begin
          nd = 0;
          if (m_cnt[i] + 1 >= m_prd[i]) begin nc = 0; wrap = 1; end
          else nc = m_cnt[i] + 1;
        end else if (m_down[i] == 0 && m_cnt[i] < m_prd[i]) begin
          nc = m_cnt[i] + 1;
        end else if (m_cnt[i] <= 1) begin
          nc = 0; nd = 0; wrap = 1;
        end else begin
          nc = m_cnt[i] - 1; nd = 1;
        end
        wrap = wrap && tick;
        if (wrap) ev |= (1 << i);
        // staging commit and register writes
        if (wrap && m_pend[i] != 0) begin
          if (m_tgt[i] != 0) m_prd[i] = m_stg[i]; else m_cmp[i] = m_stg[i];
        end
        if (cw && (a % 'h20) == 'h04 && m_run[i] == 0) m_cmp[i] = w & 'hFFFF;
        if (cw && (a % 'h20) == 'h08 && m_run[i] == 0) m_prd[i] = w & 'hFFFF;
        if (cw && (a % 'h20) == 'h10) begin
          m_stg[i] = w & 'hFFFF;
          if (m_run[i] == 0) begin
            if (m_tgt[i] != 0) m_prd[i] = m_stg[i]; else m_cmp[i] = m_stg[i];
          end
        end
        if (halt) m_pend[i] = 0;
        else if (cw && (a % 'h20) == 'h10 && m_run[i] != 0) m_pend[i] = 1;
        else if (wrap) m_pend[i] = 0;
        // counter and divider use the old run state
        if (m_run[i] == 0 || tick) m_div[i] = 0; else m_div[i] = m_div[i] + 1;
        if (m_run[i] == 0 || halt) begin m_cnt[i] = 0; m_down[i] = 0; end
        else if (tick) begin m_cnt[i] = nc; m_down[i] = nd; end
        if (cw && (a % 'h20) == 'h00) begin
          m_pre[i] = (w & 'hF) > 10 ? 10 : (w & 'hF);
          m_ctr[i] = (w >> 8) & 1;
          m_pol[i] = (w >> 9) & 1;
          m_tgt[i] = (w >> 10) & 1;
        end
        if (halt) m_run[i] = 0; else if (go) m_run[i] = 1;
      end
      if (bus_re && g && (a % 'h20) == 'h1C) m_ip = 0;
      m_ip = m_ip | ev;
      if (bus_we && g && (a % 'h20) == 'h10) m_im = m_im | (w & 'hF);
      if (bus_we && g && (a % 'h20) == 'h14) m_im = m_im & ~(w & 'hF);
    end
  end

  function automatic logic [31:0] exp_read(input int a);
    int ch, o, r;
    o = a % 'h20;
    r = 0;
    if (a < 'h20) begin
      if (o == 'h0C) for (int i = 0; i < NCH; i++) r |= m_run[i] << i;
      if (o == 'h18) r = m_im;
      if (o == 'h1C) r = m_ip;
    end else if (a >= 'h200 && a < 'h280) begin
      ch = (a - 'h200) / 'h20;
      case (o)
        'h00: r = m_pre[ch] | (m_ctr[ch] << 8) | (m_pol[ch] << 9) | (m_tgt[ch] << 10);
        'h04: r = m_cmp[ch];
        'h08: r = m_prd[ch];
        'h0C: r = m_cnt[ch];
        'h10: r = m_stg[ch];
        default: r = 0;
      endcase
    end
    return 32'(r);
  endfunction

  function automatic logic [3:0] exp_pwm();
    logic [3:0] v;
    for (int i = 0; i < NCH; i++)
      v[i] = (m_run[i] == 0) ? (m_pol[i] == 0) : ((m_cnt[i] >= m_cmp[i]) == (m_pol[i] != 0));
    return v;
  endfunction

  // per-cycle comparison of the outputs against the model (R7, R11)
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R7 pwm_out", 32'(pwm_out), 32'(exp_pwm()));
      chk("R11 irq", 32'(irq), 32'((m_ip & m_im) != 0));
    end
  end

  function automatic logic [11:0] chaddr(input int n, input int o);
    return 12'('h200 + n * 'h20 + o);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1;
    v = bus_rdata;
    chk(tag, v, exp_read(int'(a)));
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live  = 1;

    // reset state
    rd(12'h00C, "R2 status after reset", v);
    chk("R2 status zero", v, 32'h0);
    chk("R3 idle level after reset", 32'(pwm_out), 32'hF);
    rd(chaddr(0, 'h00), "R1 mode after reset", v);

    // configuration while stopped (R8 direct writes)
    wr(chaddr(0, 'h00), 32'h200); wr(chaddr(0, 'h04), 4);  wr(chaddr(0, 'h08), 10);
    wr(chaddr(1, 'h00), 32'h300); wr(chaddr(1, 'h04), 2);  wr(chaddr(1, 'h08), 6);
    wr(chaddr(2, 'h00), 32'h202); wr(chaddr(2, 'h04), 1);  wr(chaddr(2, 'h08), 5);
    wr(chaddr(3, 'h00), 32'h000); wr(chaddr(3, 'h04), 3);  wr(chaddr(3, 'h08), 8);
    rd(chaddr(0, 'h08), "R8 period written while stopped", v);
    chk("R8 period value", v, 32'd10);

    // joint start of channels 0 and 1
    wr(12'h004, 32'h3);
    rd(12'h00C, "R2 status after start", v);
    chk("R2 two running", v, 32'h3);
    rd(chaddr(0, 'h0C), "R5 left counter", v);
    rd(chaddr(1, 'h0C), "R6 center counter", v);
    wr(12'h004, 32'h0);
    rd(12'h00C, "R2 zero mask no effect", v);
    chk("R2 still two running", v, 32'h3);
    for (int k = 0; k < 8; k++) begin
      idle(3);
      rd(chaddr(k % 2, 'h0C), "R6 counter trace", v);
    end

    // prescaled channel and inverted polarity channel
    wr(12'h004, 32'hC);
    for (int k = 0; k < 10; k++) begin
      idle(2);
      rd(chaddr(2, 'h0C), "R4 prescaled counter", v);
    end

    // running compare write ignored
    wr(chaddr(0, 'h04), 7);
    rd(chaddr(0, 'h04), "R8 running write", v);
    chk("R8 compare unchanged", v, 32'd4);

    // staged compare
    wr(chaddr(0, 'h10), 2);
    rd(chaddr(0, 'h04), "R9 staged not yet visible", v);
    chk("R9 compare still old", v, 32'd4);
    idle(12);
    rd(chaddr(0, 'h04), "R9 staged compare", v);
    chk("R9 compare committed", v, 32'd2);

    // staged period
    wr(chaddr(0, 'h00), 32'h600);
    wr(chaddr(0, 'h10), 12);
    rd(chaddr(0, 'h08), "R9 period before boundary", v);
    idle(15);
    rd(chaddr(0, 'h08), "R9 staged period", v);
    chk("R9 period committed", v, 32'd12);

    // interrupts
    wr(12'h010, 32'h1);
    rd(12'h018, "R11 mask readback", v);
    chk("R11 mask bit 0", v, 32'h1);
    idle(14);
    rd(12'h01C, "R10 pending read", v);
    chk("R10 channel 0 pending", 32'(v[0]), 32'h1);
    wr(12'h014, 32'h1);
    rd(12'h018, "R11 mask cleared", v);
    chk("R11 mask zero", v, 32'h0);

    // mode masking and prescaler clamp
    wr(chaddr(3, 'h00), 32'hFFFF_FFFF);
    rd(chaddr(3, 'h00), "R1 masked mode", v);
    chk("R1 mode value", v, 32'h70A);

    // stop channel 0
    wr(12'h008, 32'h1);
    rd(12'h00C, "R3 status after stop", v);
    chk("R3 three running", v, 32'hE);
    rd(chaddr(0, 'h0C), "R3 stopped counter", v);
    chk("R3 counter zero", v, 32'h0);
    chk("R3 idle level", 32'(pwm_out[0]), 32'h0);
    wr(12'h008, 32'h0);
    rd(12'h00C, "R3 zero stop mask", v);
    chk("R3 status unchanged", v, 32'hE);

    // direct writes while stopped
    wr(chaddr(0, 'h04), 5);
    rd(chaddr(0, 'h04), "R8 stopped compare", v);
    chk("R8 compare direct", v, 32'd5);
    wr(chaddr(0, 'h10), 9);
    rd(chaddr(0, 'h08), "R9 stopped staging direct", v);
    chk("R9 period direct", v, 32'd9);

    // all interrupts enabled, then clear by read
    wr(12'h010, 32'hF);
    idle(30);
    rd(12'h01C, "R10 pending several", v);
    rd(12'h01C, "R10 pending after clear", v);
    wr(12'h008, 32'hF);
    idle(2);
    rd(12'h01C, "R10 drain", v);
    idle(2);
    chk("R11 irq low with nothing pending", 32'(irq), 32'h0);

    done = 1;
    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule